// File: doc/BRIEF.md
# Indirect Register Window with Interrupt Merge

This block sits on a simple host bus and presents four byte-wide registers, chosen by a chip select and a two-bit address. Two of the four give access to a bank of 64 internal byte registers. The host first loads a pointer, which is a 6-bit index plus an auto-advance bit. It then reads or writes the data port. When auto-advance is set, the index moves forward after every data-port access, so sequential sweeps need no pointer rewrites.

A third register is the interrupt control and status byte. Four event sources (receive, transmit, video line, timer) each set a sticky pending flag. A single interrupt output goes high while any pending flag has its enable set. Reading that register returns the flags and clears them. An event that arrives in the same cycle as the clearing read survives the read. The remaining address returns an external status byte. Read data is registered and appears on `rdata` one cycle after the read strobe. It holds until the next read.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset `rdata` is 0x00, `irq` is 0, all enables and flags are 0, the pointer reads 0x00 and every bank entry reads 0x00.
- R2: Address 2 holds the pointer. Bit 7 is auto-advance and bits 5:0 are the index. Bit 6 always reads 0.
- R3: A write to address 3 stores the byte at the current index. A later read of address 3 at the same index returns it.
- R4: With auto-advance 1, every read or write of address 3 adds one to the index, wrapping 63 to 0. With auto-advance 0 the index does not change.
- R5: With auto-advance 1, reads of address 3 on consecutive cycles return consecutive locations, because each read captures its data before the index moves.
- R6: Address 0 reads {rx_flag, tx_flag, vid_flag, rx_en, tx_en, vid_en, tmr_flag, tmr_en} from bit 7 down to bit 0. Writes change only bits 4, 3, 2 and 0.
- R7: A pulse on `evt_in[k]` sets flag k on the next edge. Bit 0 is rx, bit 1 is tx, bit 2 is video and bit 3 is timer. `irq` is high while any flag and its enable are both 1.
- R8: A read of address 0 returns the flags as they were before the read and clears them. `irq` is then low from the following cycle unless a new event arrives.
- R9: An event that arrives in the same cycle as a clearing read of address 0 stays set after that read.
- R10: A read of address 1 returns `status_in`.
- R11: With `sel` low, reads and writes have no effect: `rdata` holds and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select for the register window |
| addr | input | 2 | Register address within the window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| status_in | input | 8 | External status byte returned at address 1 |
| evt_in | input | 4 | Event pulses: rx, tx, video, timer (bit 0 to bit 3) |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Merged interrupt request |

## Verification
The assertions assume that a read strobe and a write strobe are never both high in the same selected cycle. They also assume that the inputs hold defined values from the first clock while reset is held. The bench keeps to this: every bus access drives exactly one strobe, and all inputs start at zero. Event pulses are placed either in idle cycles or deliberately in the same cycle as a clearing read. The rise-of-interrupt property can therefore be traced to an event or a control write in the cycle before.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int BYTE_W = 8;
  localparam int SRC_N  = 4;

  typedef enum logic [1:0] {
    WIN_CTL  = 2'd0,
    WIN_STAT = 2'd1,
    WIN_PTR  = 2'd2,
    WIN_DATA = 2'd3
  } win_addr_e;

  // source order in every 4-bit vector: 0 rx, 1 tx, 2 video, 3 timer
  function automatic logic [BYTE_W-1:0] ctl_pack(input logic [SRC_N-1:0] fl,
                                                 input logic [SRC_N-1:0] en);
    return {fl[0], fl[1], fl[2], en[0], en[1], en[2], fl[3], en[3]};
  endfunction

  function automatic logic [SRC_N-1:0] ctl_enables(input logic [BYTE_W-1:0] d);
    return {d[0], d[2], d[3], d[4]};
  endfunction

  function automatic logic irq_merge(input logic [SRC_N-1:0] fl,
                                     input logic [SRC_N-1:0] en);
    return |(fl & en);
  endfunction
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
(
  input  logic       sel,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  output logic [3:0] wr_hit,
  output logic [3:0] rd_hit
);
  for (genvar g = 0; g < 4; g++) begin : g_hit
    assign wr_hit[g] = sel && wr_en && (addr == 2'(g));
    assign rd_hit[g] = sel && rd_en && (addr == 2'(g));
  end
endmodule

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_auto,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             data_acc,
  output logic [IDX_W-1:0] idx,
  output logic             auto_inc
);
  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] i);
    return i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      auto_inc <= 1'b0;
    end else if (load) begin
      idx      <= load_idx;
      auto_inc <= load_auto;
    end else if (data_acc && auto_inc) begin
      idx <= idx_step(idx);
    end
  end
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
  parameter int IDX_W  = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/regwin_irq.sv
module regwin_irq
  import regwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_load,
  input  logic [SRC_N-1:0] en_new,
  input  logic             clr_rd,
  input  logic [SRC_N-1:0] evt,
  output logic [SRC_N-1:0] flags,
  output logic [SRC_N-1:0] enables,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       enables <= '0;
    else if (en_load) enables <= en_new;
  end

  for (genvar k = 0; k < SRC_N; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[k] <= 1'b0;
      else        flags[k] <= evt[k] | (flags[k] & ~clr_rd);
    end
  end

  assign irq = irq_merge(flags, enables);
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] status_in,
  input  logic [SRC_N-1:0]  evt_in,
  output logic [BYTE_W-1:0] rdata,
  output logic              irq
);
  localparam int PAD_W = BYTE_W - 1 - IDX_W;

  logic [3:0]        wr_hit, rd_hit;
  logic [IDX_W-1:0]  ptr_idx;
  logic              ptr_auto;
  logic              data_acc;
  logic [BYTE_W-1:0] bank_q;
  logic [SRC_N-1:0]  irq_flags, irq_en;
  logic [BYTE_W-1:0] rd_mux;
  logic              any_rd;

  regwin_decode u_dec (
    .sel(sel), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  assign data_acc = wr_hit[WIN_DATA] | rd_hit[WIN_DATA];

  regwin_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(wr_hit[WIN_PTR]), .load_auto(wdata[BYTE_W-1]),
    .load_idx(wdata[IDX_W-1:0]), .data_acc(data_acc),
    .idx(ptr_idx), .auto_inc(ptr_auto)
  );

  regwin_bank #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(wr_hit[WIN_DATA]),
    .idx(ptr_idx), .wdata(wdata), .rdata(bank_q)
  );

  regwin_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .en_load(wr_hit[WIN_CTL]), .en_new(ctl_enables(wdata)),
    .clr_rd(rd_hit[WIN_CTL]), .evt(evt_in),
    .flags(irq_flags), .enables(irq_en), .irq(irq)
  );

  always_comb begin
    unique case (win_addr_e'(addr))
      WIN_CTL:  rd_mux = ctl_pack(irq_flags, irq_en);
      WIN_STAT: rd_mux = status_in;
      WIN_PTR:  rd_mux = {ptr_auto, {PAD_W{1'b0}}, ptr_idx};
      default:  rd_mux = bank_q;
    endcase
  end

  assign any_rd = |rd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (any_rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic             rd_en,
  input logic [3:0]       evt_in,
  input logic [7:0]       rdata,
  input logic             irq,
  input logic [IDX_W-1:0] idx,
  input logic             autoinc,
  input logic [3:0]       flags
);
  logic data_hit, ctl_rd, ctl_wr;
  assign data_hit = sel && (addr == 2'd3) && (rd_en || wr_en);
  assign ctl_rd   = sel && rd_en && (addr == 2'd0);
  assign ctl_wr   = sel && wr_en && (addr == 2'd0);

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> !(rd_en && wr_en));

  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && autoinc) |=> (idx == IDX_W'($past(idx) + 1'b1)));

  assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && !autoinc) |=> $stable(idx));

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((evt_in != 4'd0) || ctl_wr));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && evt_in == 4'd0) |=> !irq);

  assert_keep_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |=> ((flags & $past(evt_in)) == $past(evt_in)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(rdata) && $stable(idx)));
endmodule

bind regwin_ctrl regwin_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_en(wr_en),
  .rd_en(rd_en), .evt_in(evt_in), .rdata(rdata), .irq(irq),
  .idx(ptr_idx), .autoinc(ptr_auto), .flags(irq_flags)
);

// File: tb/regwin_ctrl_tb.sv
module regwin_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'd0, status_in = 8'd0;
  logic [3:0] evt_in = 4'd0;
  logic [7:0] rdata;
  logic       irq;

  always #5 clk = ~clk;

  regwin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .status_in(status_in), .evt_in(evt_in),
    .rdata(rdata), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;

  // scoreboard queues
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // bench-side model
  logic [7:0] m_mem [64];
  logic [5:0] m_idx = 6'd0;
  logic       m_ai  = 1'b0;
  logic [3:0] m_en  = 4'd0;
  logic [3:0] m_fl  = 4'd0;

  function automatic logic [7:0] model_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {m_fl[0], m_fl[1], m_fl[2], m_en[0], m_en[1], m_en[2], m_fl[3], m_en[3]};
      2'd1:    return status_in;
      2'd2:    return {m_ai, 1'b0, m_idx};
      default: return m_mem[m_idx];
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // one bus cycle; called at a negedge, returns at the next negedge
  task automatic access(input bit s, input logic [1:0] a, input bit w, input bit r,
                        input logic [7:0] d, input logic [3:0] ev, input string req);
    sel = s; addr = a; wr_en = w; rd_en = r; wdata = d; evt_in = ev;
    if (s && r) begin
      exp_q.push_back(model_rd(a));
      tag_q.push_back(req);
    end
    if (s && r && a == 2'd0) m_fl = ev;
    else                     m_fl = m_fl | ev;
    if (s && w) begin
      case (a)
        2'd0: m_en = {d[0], d[2], d[3], d[4]};
        2'd2: begin m_ai = d[7]; m_idx = d[5:0]; end
        2'd3: m_mem[m_idx] = d;
        default: ;
      endcase
    end
    if (s && a == 2'd3 && (r || w) && m_ai) m_idx = m_idx + 6'd1;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; evt_in = 4'd0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    access(1'b1, a, 1'b1, 1'b0, d, 4'd0, "");
  endtask

  task automatic rd(input logic [1:0] a, input string req);
    access(1'b1, a, 1'b0, 1'b1, 8'd0, 4'd0, req);
  endtask

  task automatic pulse(input logic [3:0] ev);
    access(1'b0, 2'd0, 1'b0, 1'b0, 8'd0, ev, "");
  endtask

  // monitor: pops one expected item per read strobe seen at the edge
  logic rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= sel & rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: unexpected read data 0x%02h expected none", rdata);
      end else begin
        check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    for (int i = 0; i < 64; i++) m_mem[i] = 8'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rdata, 8'h00, "R1 rdata");
    check({7'd0, irq}, 8'h00, "R1 irq");
    rd(2'd0, "R1 ctl reg");
    rd(2'd2, "R1 pointer");
    rd(2'd3, "R1 bank entry");

    // R2 pointer fields, bit 6 reads zero
    wr(2'd2, 8'h85);
    rd(2'd2, "R2 pointer 0x85");
    wr(2'd2, 8'hFF);
    rd(2'd2, "R2 bit6 zero");

    // R3 / R4 hold: no auto-advance
    wr(2'd2, 8'h10);
    wr(2'd3, 8'hA5);
    rd(2'd3, "R3 stored byte");
    rd(2'd3, "R4 index held");
    rd(2'd2, "R4 pointer unchanged");

    // R4 wrap with writes
    wr(2'd2, 8'h80 | 8'd62);
    wr(2'd3, 8'h11);
    wr(2'd3, 8'h22);
    wr(2'd3, 8'h33);
    rd(2'd2, "R4 wrap to 1");

    // R5 back-to-back reads
    wr(2'd2, 8'h80 | 8'd62);
    rd(2'd3, "R5 loc 62");
    rd(2'd3, "R5 loc 63");
    rd(2'd3, "R5 loc 0");
    rd(2'd3, "R5 loc 1");

    // R10 status
    status_in = 8'h5A;
    rd(2'd1, "R10 status");

    // R6 only enable bits writable
    wr(2'd0, 8'hFF);
    rd(2'd0, "R6 enables only");
    wr(2'd0, 8'h00);

    // R7 flag without enable: no irq
    pulse(4'b0001);
    check({7'd0, irq}, 8'h00, "R7 masked irq");
    rd(2'd0, "R7 rx flag pending");
    wr(2'd0, 8'h10);
    pulse(4'b0001);
    check({7'd0, irq}, 8'h01, "R7 rx irq");
    // R8 read clears
    rd(2'd0, "R8 read returns flags");
    check({7'd0, irq}, 8'h00, "R8 irq cleared");
    rd(2'd0, "R8 flags cleared");

    // R7 timer source
    wr(2'd0, 8'h01);
    pulse(4'b1000);
    check({7'd0, irq}, 8'h01, "R7 timer irq");
    rd(2'd0, "R7 timer flag");

    // R9 event during clearing read
    wr(2'd0, 8'h08);
    pulse(4'b0100);
    access(1'b1, 2'd0, 1'b0, 1'b1, 8'd0, 4'b0010, "R9 pre-clear value");
    check({7'd0, irq}, 8'h01, "R9 tx irq kept");
    rd(2'd0, "R9 tx flag kept");

    // R11 deselected accesses
    held = rdata;
    access(1'b0, 2'd2, 1'b1, 1'b0, 8'h3F, 4'd0, "");
    access(1'b0, 2'd1, 1'b0, 1'b1, 8'd0, 4'd0, "");
    check(rdata, held, "R11 rdata held");
    rd(2'd2, "R11 pointer untouched");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule